// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers interrupt requests from two groups of producers into one host-facing interrupt line. The first group is a set of GPIO bank summary lines: each bank already holds its own per-pin pending state and masking, and simply reports "something pending" on one wire. The second group is a set of other peripheral request lines. Both groups appear in one pending status word. Bank summaries occupy the low bits, and peripheral requests follow in ascending order from the bit just above the last bank.

Software controls the block through a small 16-bit register port. One register holds the per-source enable bits. In that register a set bit lets the source through, and the same register carries a global enable bit. A second register holds a clock-select bit that turns the controller's logic on. The host line is registered and driven low whenever nothing enabled is pending. The host watches this line for rising edges, so every new batch of work after a quiet period produces a fresh edge.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable register, the global enable and the clock-select bit are all zero, and `irq_out` is low.
- R2: Status bits 0..3 equal `bank_pend[3:0]` combinationally, at every moment, whatever the clock-select bit is.
- R3: While the clock-select bit is 1, a clock edge loads `periph_req[k]` into status bit 4+k. A peripheral status bit therefore stays set for as long as its request stays high and clears one edge after the request drops.
- R4: While the clock-select bit is 0, the peripheral status bits hold their value across edges and `irq_out` is low one edge later.
- R5: Enable-register bit i (1 = enabled) admits status bit i to the host line. A pending but disabled source shows in the status read and does not raise `irq_out`.
- R6: The global enable sits at bit 15 of the enable register. While it is 0, `irq_out` is low one edge later.
- R7: `irq_out` is a register. It rises one edge after an enabled status bit is set while the global enable and the clock select are both 1. It falls one edge after no enabled bit remains, so the next event gives a new rising edge.
- R8: Register map, on a 2-bit address: 0 = status (read-only, bits 9..0, writes ignored); 1 = enables (bits 9..0 and bit 15 writable, other bits read 0); 2 = control (bit 0 = clock select); 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_pend | input | 4 | GPIO bank summary pending lines |
| periph_req | input | 6 | Peripheral interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_out | output | 1 | Interrupt line to the host |

## Verification
A wrong peripheral status bit can be read at address 0 one edge after the request changes. It also reaches `irq_out` on the following edge, which is two edges after the input moves. A wrong enable bit or global enable shows only through `irq_out`, one edge after the source becomes pending: either a pending source stays silent, or a disabled one raises the line. A clock-select fault shows as peripheral status that changes while the controller is switched off, or as a host line that is high while it is off.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BANKS_DEF  = 4;
  localparam int PERIPH_DEF = 6;
  localparam int DW_DEF     = 16;
  localparam int GIE_DEF    = 15;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_EN   = 2'd1,
    A_CTRL = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // Any enabled pending source, on zero-extended 32-bit words.
  function automatic logic any_hit(input logic [31:0] stat, input logic [31:0] en);
    return |(stat & en);
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int NS  = 10,
  parameter int DW  = 16,
  parameter int GIE = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [NS-1:0] stat,
  output logic [DW-1:0] rdata,
  output logic [NS-1:0] en_q,
  output logic          gie_q,
  output logic          clksel_q
);
  import irqc_pkg::*;

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      gie_q    <= 1'b0;
      clksel_q <= 1'b0;
    end else if (we) begin
      if (addr == A_EN) begin
        en_q  <= wdata[NS-1:0];
        gie_q <= wdata[GIE];
      end
      if (addr == A_CTRL) clksel_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: rdata[NS-1:0] = stat;
      A_EN: begin
        rdata[NS-1:0] = en_q;
        rdata[GIE]    = gie_q;
      end
      A_CTRL: rdata[0] = clksel_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int NB = 4,
  parameter int NP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clksel,
  input  logic [NB-1:0]    bank_pend,
  input  logic [NP-1:0]    periph_req,
  output logic [NB+NP-1:0] stat
);
  logic [NP-1:0] per_q;

  genvar k;
  generate
    for (k = 0; k < NP; k++) begin : g_per
      always_ff @(posedge clk) begin
        if (!rst_n)      per_q[k] <= 1'b0;
        else if (clksel) per_q[k] <= periph_req[k];
      end
    end
  endgenerate

  assign stat = {per_q, bank_pend};
endmodule

// File: rtl/irqc_line.sv
module irqc_line #(
  parameter int NS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clksel,
  input  logic          gie,
  input  logic [NS-1:0] stat,
  input  logic [NS-1:0] en,
  output logic          hit,
  output logic          irq_q
);
  import irqc_pkg::*;

  assign hit = any_hit(32'(stat), 32'(en));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= clksel & gie & hit;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NB  = irqc_pkg::BANKS_DEF,
  parameter int NP  = irqc_pkg::PERIPH_DEF,
  parameter int DW  = irqc_pkg::DW_DEF,
  parameter int GIE = irqc_pkg::GIE_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] bank_pend,
  input  logic [NP-1:0] periph_req,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_out
);
  localparam int NS = NB + NP;

  logic [NS-1:0] status_w;
  logic [NS-1:0] en_w;
  logic          gie_w;
  logic          clksel_w;
  logic          hit_w;

  irqc_regs #(.NS(NS), .DW(DW), .GIE(GIE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .stat(status_w), .rdata(reg_rdata),
    .en_q(en_w), .gie_q(gie_w), .clksel_q(clksel_w)
  );

  irqc_capture #(.NB(NB), .NP(NP)) u_cap (
    .clk(clk), .rst_n(rst_n), .clksel(clksel_w),
    .bank_pend(bank_pend), .periph_req(periph_req), .stat(status_w)
  );

  irqc_line #(.NS(NS)) u_line (
    .clk(clk), .rst_n(rst_n), .clksel(clksel_w), .gie(gie_w),
    .stat(status_w), .en(en_w), .hit(hit_w), .irq_q(irq_out)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NB = 4,
  parameter int NP = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clksel,
  input logic             gie,
  input logic [NB-1:0]    bank_pend,
  input logic [NP-1:0]    periph_req,
  input logic [NB+NP-1:0] status,
  input logic             hit,
  input logic             irq_out
);
  // R2
  bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[NB-1:0] == bank_pend);

  // R3
  periph_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clksel |=> status[NB+NP-1:NB] == $past(periph_req));

  // R4
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clksel |=> $stable(status[NB+NP-1:NB]) && !irq_out);

  // R6
  gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq_out);

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(hit && gie && clksel));

  // R7
  quiet_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !irq_out);
endmodule

bind irqc_top irqc_chk #(.NB(NB), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .clksel(clksel_w), .gie(gie_w),
  .bank_pend(bank_pend), .periph_req(periph_req), .status(status_w),
  .hit(hit_w), .irq_out(irq_out)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bank_pend = '0;
  logic [5:0]  periph_req = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .bank_pend(bank_pend), .periph_req(periph_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
  endtask

  function automatic logic [15:0] rd(input logic [1:0] a);
    reg_addr = a;
    return reg_rdata;
  endfunction

  task automatic rdchk(input string req, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset;
    rdchk("R1 enables", 2'd1, 16'h0000);
    rdchk("R1 control", 2'd2, 16'h0000);
    rdchk("R1 status", 2'd0, 16'h0000);
    chk("R1 irq", {15'd0, irq_out}, 16'h0000);
  endtask

  task automatic t_regmap;
    wr(2'd1, 16'hFFFF);
    rdchk("R8 enable bits", 2'd1, 16'h83FF);
    wr(2'd0, 16'hFFFF);
    rdchk("R8 status ro", 2'd0, 16'h0000);
    wr(2'd2, 16'hFFFF);
    rdchk("R8 control", 2'd2, 16'h0001);
    rdchk("R8 addr3", 2'd3, 16'h0000);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_bank;
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'h83FF);
    bank_pend = 4'b0101;
    rdchk("R2 bank status", 2'd0, 16'h0005);
    chk("R7 irq not yet", {15'd0, irq_out}, 16'h0000);
    tick(1);
    chk("R7 irq rise bank", {15'd0, irq_out}, 16'h0001);
    bank_pend = 4'b0000;
    tick(1);
    chk("R7 irq fall bank", {15'd0, irq_out}, 16'h0000);
  endtask

  task automatic t_periph;
    periph_req = 6'b000100;
    tick(1);
    rdchk("R3 periph set", 2'd0, 16'h0040);
    tick(1);
    chk("R7 irq periph", {15'd0, irq_out}, 16'h0001);
    periph_req = 6'b000000;
    tick(1);
    rdchk("R3 periph clear", 2'd0, 16'h0000);
    tick(1);
    chk("R7 irq drop", {15'd0, irq_out}, 16'h0000);
    bank_pend = 4'b1000;
    tick(1);
    chk("R7 fresh edge", {15'd0, irq_out}, 16'h0001);
    bank_pend = 4'b0000;
    tick(1);
  endtask

  task automatic t_mask;
    wr(2'd1, 16'h8010);
    periph_req = 6'b000010;
    tick(2);
    rdchk("R5 disabled shows", 2'd0, 16'h0020);
    chk("R5 disabled silent", {15'd0, irq_out}, 16'h0000);
    periph_req = 6'b000011;
    tick(2);
    chk("R5 enabled fires", {15'd0, irq_out}, 16'h0001);
    periph_req = 6'b000000;
    tick(2);
  endtask

  task automatic t_gie;
    wr(2'd1, 16'h03FF);
    bank_pend = 4'b0010;
    tick(2);
    chk("R6 no global", {15'd0, irq_out}, 16'h0000);
    wr(2'd1, 16'h83FF);
    tick(1);
    chk("R6 global on", {15'd0, irq_out}, 16'h0001);
    bank_pend = 4'b0000;
    tick(1);
  endtask

  task automatic t_clksel;
    periph_req = 6'b100000;
    tick(1);
    wr(2'd2, 16'h0000);
    periph_req = 6'b001000;
    tick(2);
    rdchk("R4 status held", 2'd0, 16'h0200);
    chk("R4 irq off", {15'd0, irq_out}, 16'h0000);
    bank_pend = 4'b0001;
    rdchk("R2 bank while off", 2'd0, 16'h0201);
    bank_pend = 4'b0000;
    wr(2'd2, 16'h0001);
    tick(1);
    rdchk("R3 resume load", 2'd0, 16'h0080);
    periph_req = 6'b000000;
    tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset;
    t_regmap;
    t_bank;
    t_periph;
    t_mask;
    t_gie;
    t_clksel;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule